// File: doc/BRIEF.md
# Byte-Paced I2C Master Controller

This block is an I2C master that moves one byte for each software handshake. A small register bus gives access to a control register, a status register, an own-address register and a data/shift register. Software chooses the transfer direction, loads the address byte and requests a START. The controller then drives open-drain SCL and SDA: a START condition, eight data bits with the most significant bit first, and a ninth acknowledge clock. After each byte it raises a pending flag and holds SCL low. It waits in that state until software clears the flag.

For a write, software loads the next byte during the pause and clears pending. For a read, software collects the received byte from the data register and decides whether the next byte gets an ACK. To end a transfer, software writes the busy/start bit to 0 and then clears pending. The controller sends STOP, clears busy by itself and falls back to the idle slave mode. If SDA reads low while the controller leaves it released in a transmitted bit, the transfer is abandoned and the loss is reported. The SCL rate comes from a selectable pre-divider and a 4-bit prescaler.

Top module: `twi_byte_ctrl`

## Requirements
- R1: After reset, the control register (index 0) and the status register (index 1) both read 0x00, SCL and SDA are released (not driven low), and irq is low.
- R2: The SCL period during a byte is D*(P+1) input clocks. D is 16 when control bit 1 is 0 and 512 when it is 1. P is control bits 7:4.
- R3: Software first writes status with bits 1:0 = mode (2 master receive, 3 master transmit) and bit 3 = output enable, then writes the address byte to the data register (index 3), then writes status again with bit 2 = 1. The controller then makes a START (SDA falls while SCL is high) and shifts the address byte out MSB first.
- R4: After the ninth clock of every byte, the pending flag (control bit 3) is set and SCL is held low until software writes control with bit 3 = 0. Writing 1 to bit 3 leaves it as it is.
- R5: irq is high exactly when the pending flag and the interrupt enable (control bit 2) are both 1.
- R6: Status bit 7 holds the SDA level sampled in the ninth clock of the last byte: 0 for ACK, 1 for NACK.
- R7: In master transmit, clearing pending with busy still requested sends the data register contents as the next byte. During the pause, SDA follows the MSB of a newly written data byte within a few cycles.
- R8: In master receive, the eight bits read from the bus land in the data register. The ninth clock drives SDA low (ACK) when control bit 0 is 1 and leaves it released (NACK) when it is 0.
- R9: Writing status bit 2 = 0 during a pause and then clearing pending produces a STOP (SDA rises while SCL is high). Afterwards status reads busy (bit 2) = 0 and mode = 0 (slave receive) without any further write.
- R10: If SDA is sampled low in a transmitted bit in which the controller leaves it released, status bit 4 (arbitration lost) is set, both lines are released, pending is set, and busy and mode drop to 0.
- R11: Writing status with bit 3 = 0 abandons any transfer, releases both lines within three cycles and clears busy.
- R12: The own-address register (index 2) reads back the last value written to it. Status bits 6 and 5 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register index: 0 control, 1 status, 2 own address, 3 data |
| reg_wr | input | 1 | Write strobe for one cycle |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| scl_i | input | 1 | Level seen on the SCL line |
| sda_i | input | 1 | Level seen on the SDA line |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| irq | output | 1 | Interrupt request |

## Verification
Register writes take effect at the next edge, and reads are combinational, so the bench samples them half a cycle after it sets the index. Bus activity follows a quarter-bit tick. A byte with its acknowledge slot takes nine SCL periods of 16*(P+1) or 512*(P+1) clocks, so the bench polls the pending flag rather than counting to a fixed cycle. The bench measures the SCL period between two rising edges it observes on the line. The line drivers are registered, and SDA changes one cycle after SCL has fallen. For that reason the bench checks the line levels a few cycles after a write that releases the lines or changes the data MSB, and never at the edge itself.

// File: rtl/twi_pkg.sv
package twi_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_START,
    S_BIT,
    S_HOLD,
    S_STOP
  } seq_state_t;

  localparam int unsigned REG_AW = 2;
  localparam logic [REG_AW-1:0] RA_CTL = 2'd0;
  localparam logic [REG_AW-1:0] RA_STA = 2'd1;
  localparam logic [REG_AW-1:0] RA_OWN = 2'd2;
  localparam logic [REG_AW-1:0] RA_DAT = 2'd3;

  localparam logic [1:0] MODE_SRX = 2'd0;
  localparam logic [1:0] MODE_STX = 2'd1;
  localparam logic [1:0] MODE_MRX = 2'd2;
  localparam logic [1:0] MODE_MTX = 2'd3;

  // control register field positions
  localparam int unsigned CB_ACK  = 0;
  localparam int unsigned CB_DIV  = 1;
  localparam int unsigned CB_IEN  = 2;
  localparam int unsigned CB_PEND = 3;
  localparam int unsigned CB_PSC  = 4;

  // status register field positions
  localparam int unsigned SB_BUSY = 2;
  localparam int unsigned SB_OEN  = 3;
endpackage

// File: rtl/twi_qtick.sv
module twi_qtick #(
  parameter int unsigned DIV_LO = 16,
  parameter int unsigned DIV_HI = 512,
  parameter int unsigned PSC_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             div_sel,
  input  logic [PSC_W-1:0] psc,
  output logic             tick
);
  localparam int unsigned Q_LO = DIV_LO / 4;
  localparam int unsigned Q_HI = DIV_HI / 4;
  localparam int unsigned CW   = $clog2(Q_HI * (1 << PSC_W));

  logic [CW-1:0] cnt_q, cnt_d, lim;

  always_comb begin
    lim  = CW'((div_sel ? Q_HI : Q_LO) * (32'(psc) + 32'd1) - 32'd1);
    tick = run && (cnt_q == lim);
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/twi_csr.sv
module twi_csr
  import twi_pkg::*;
#(
  parameter int unsigned PSC_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              pend,
  input  logic              busy,
  input  logic              arb,
  input  logic              last_bit,
  input  logic [1:0]        mode,
  input  logic [7:0]        shift,
  output logic              ack_en,
  output logic              div_sel,
  output logic [PSC_W-1:0]  psc,
  output logic              out_en,
  output logic              ctl_wr,
  output logic              sta_wr,
  output logic              dat_wr,
  output logic              pend_clr,
  output logic              irq
);
  logic             ien_q, ien_d, ack_q, ack_d, div_q, div_d, oen_q, oen_d;
  logic [PSC_W-1:0] psc_q, psc_d;
  logic [7:0]       own_q, own_d;
  logic             own_wr;

  always_comb begin
    ctl_wr   = reg_wr && (reg_addr == RA_CTL);
    sta_wr   = reg_wr && (reg_addr == RA_STA);
    own_wr   = reg_wr && (reg_addr == RA_OWN);
    dat_wr   = reg_wr && (reg_addr == RA_DAT);
    pend_clr = ctl_wr && !reg_wdata[CB_PEND];

    ack_d = ctl_wr ? reg_wdata[CB_ACK] : ack_q;
    div_d = ctl_wr ? reg_wdata[CB_DIV] : div_q;
    ien_d = ctl_wr ? reg_wdata[CB_IEN] : ien_q;
    psc_d = ctl_wr ? reg_wdata[CB_PSC +: PSC_W] : psc_q;
    oen_d = sta_wr ? reg_wdata[SB_OEN] : oen_q;
    own_d = own_wr ? reg_wdata : own_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q <= 1'b0;
      div_q <= 1'b0;
      ien_q <= 1'b0;
      psc_q <= '0;
      oen_q <= 1'b0;
      own_q <= '0;
    end else begin
      ack_q <= ack_d;
      div_q <= div_d;
      ien_q <= ien_d;
      psc_q <= psc_d;
      oen_q <= oen_d;
      own_q <= own_d;
    end
  end

  always_comb begin
    ack_en  = ack_q;
    div_sel = div_q;
    psc     = psc_q;
    out_en  = oen_q;
    irq     = pend && ien_q;
    unique case (reg_addr)
      RA_CTL:  reg_rdata = {psc_q, pend, ien_q, div_q, ack_q};
      RA_STA:  reg_rdata = {last_bit, 1'b0, 1'b0, arb, oen_q, busy, mode};
      RA_OWN:  reg_rdata = own_q;
      default: reg_rdata = shift;
    endcase
  end
endmodule

// File: rtl/twi_seq.sv
module twi_seq
  import twi_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  output logic       run,
  input  logic       ack_en,
  input  logic       sta_wr,
  input  logic       dat_wr,
  input  logic       pend_clr,
  input  logic [7:0] wdata,
  input  logic       sda_i,
  output logic       busy,
  output logic [1:0] mode,
  output logic       pend,
  output logic       arb,
  output logic       last_bit,
  output logic [7:0] shift,
  output logic       scl_oe,
  output logic       sda_oe
);
  seq_state_t state_q, state_d;
  logic [1:0] qph_q, qph_d, mode_q, mode_d;
  logic [3:0] bidx_q, bidx_d;
  logic [7:0] shift_q, shift_d;
  logic       samp_q, samp_d, pend_q, pend_d, arb_q, arb_d, last_q, last_d;
  logic       first_q, first_d, stop_q, stop_d;
  logic       scl_q, scl_d, sda_q, sda_d;
  logic       tx_byte, scl_want, sda_want, go, abort, sda_load;

  always_comb begin
    tx_byte = first_q || (mode_q == MODE_MTX);
    go      = sta_wr && wdata[SB_OEN] && wdata[SB_BUSY] && wdata[1];
    abort   = sta_wr && !wdata[SB_OEN];
    run     = (state_q == S_START) || (state_q == S_BIT) || (state_q == S_STOP);
  end

  // line drive wanted by the current state (1 = pull low)
  always_comb begin
    scl_want = 1'b0;
    sda_want = 1'b0;
    unique case (state_q)
      S_START: sda_want = qph_q[1];
      S_BIT: begin
        scl_want = !qph_q[1];
        if (bidx_q == 4'd8) sda_want = !tx_byte && ack_en;
        else                sda_want = tx_byte && !shift_q[7];
      end
      S_HOLD: begin
        scl_want = 1'b1;
        sda_want = (mode_q == MODE_MTX) && !shift_q[7];
      end
      S_STOP: begin
        scl_want = !qph_q[1];
        sda_want = (qph_q != 2'd3);
      end
      default: ;
    endcase
    sda_load = scl_q || (state_q == S_IDLE) || (state_q == S_START) || (state_q == S_STOP);
    scl_d    = scl_want;
    sda_d    = sda_load ? sda_want : sda_q;
  end

  always_comb begin
    state_d = state_q;
    qph_d   = qph_q;
    bidx_d  = bidx_q;
    shift_d = shift_q;
    samp_d  = samp_q;
    pend_d  = pend_q;
    arb_d   = arb_q;
    last_d  = last_q;
    first_d = first_q;
    stop_d  = stop_q;
    mode_d  = mode_q;

    if (sta_wr) mode_d = wdata[1:0];
    if (sta_wr && !wdata[SB_BUSY] && (state_q != S_IDLE)) stop_d = 1'b1;
    if (pend_clr) pend_d = 1'b0;
    if (dat_wr && (state_q != S_BIT)) shift_d = wdata;

    if (abort) begin
      state_d = S_IDLE;
      stop_d  = 1'b0;
    end else begin
      unique case (state_q)
        S_IDLE: if (go) begin
          state_d = S_START;
          qph_d   = 2'd0;
          arb_d   = 1'b0;
          pend_d  = 1'b0;
          stop_d  = 1'b0;
          first_d = 1'b1;
        end
        S_START: if (tick) begin
          qph_d = qph_q + 2'd1;
          if (qph_q == 2'd3) begin
            state_d = S_BIT;
            bidx_d  = 4'd0;
          end
        end
        S_BIT: if (tick) begin
          qph_d = qph_q + 2'd1;
          if (qph_q == 2'd2) begin
            samp_d = sda_i;
            if ((bidx_q != 4'd8) && tx_byte && !sda_q && !sda_i) begin
              arb_d   = 1'b1;
              pend_d  = 1'b1;
              mode_d  = MODE_SRX;
              stop_d  = 1'b0;
              state_d = S_IDLE;
            end
          end
          if (qph_q == 2'd3) begin
            if (bidx_q == 4'd8) begin
              last_d  = samp_q;
              pend_d  = 1'b1;
              state_d = S_HOLD;
            end else begin
              shift_d = {shift_q[6:0], samp_q};
              bidx_d  = bidx_q + 4'd1;
            end
          end
        end
        S_HOLD: if (pend_clr) begin
          first_d = 1'b0;
          qph_d   = 2'd0;
          bidx_d  = 4'd0;
          state_d = stop_q ? S_STOP : S_BIT;
        end
        S_STOP: if (tick) begin
          qph_d = qph_q + 2'd1;
          if (qph_q == 2'd3) begin
            state_d = S_IDLE;
            mode_d  = MODE_SRX;
            stop_d  = 1'b0;
          end
        end
        default: state_d = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      qph_q   <= '0;
      bidx_q  <= '0;
      shift_q <= '0;
      samp_q  <= 1'b0;
      pend_q  <= 1'b0;
      arb_q   <= 1'b0;
      last_q  <= 1'b0;
      first_q <= 1'b0;
      stop_q  <= 1'b0;
      mode_q  <= MODE_SRX;
      scl_q   <= 1'b0;
      sda_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      qph_q   <= qph_d;
      bidx_q  <= bidx_d;
      shift_q <= shift_d;
      samp_q  <= samp_d;
      pend_q  <= pend_d;
      arb_q   <= arb_d;
      last_q  <= last_d;
      first_q <= first_d;
      stop_q  <= stop_d;
      mode_q  <= mode_d;
      scl_q   <= scl_d;
      sda_q   <= sda_d;
    end
  end

  always_comb begin
    busy     = (state_q != S_IDLE);
    mode     = mode_q;
    pend     = pend_q;
    arb      = arb_q;
    last_bit = last_q;
    shift    = shift_q;
    scl_oe   = scl_q;
    sda_oe   = sda_q;
  end
endmodule

// File: rtl/twi_byte_ctrl.sv
module twi_byte_ctrl
  import twi_pkg::*;
#(
  parameter int unsigned DIV_LO = 16,
  parameter int unsigned DIV_HI = 512,
  parameter int unsigned PSC_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic              irq
);
  logic             pend_w, busy_w, arb_w, last_w, out_en_w;
  logic [1:0]       mode_w;
  logic [7:0]       shift_w;
  logic             ack_w, div_w, ctl_wr_w, sta_wr_w, dat_wr_w, pend_clr_w;
  logic [PSC_W-1:0] psc_w;
  logic             run_w, tick_w;
  logic             scl_seen;

  // SCL is driven by this master only; its level is not needed
  always_comb scl_seen = scl_i;

  twi_csr #(.PSC_W(PSC_W)) u_csr (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_addr (reg_addr),
    .reg_wr   (reg_wr),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .pend     (pend_w),
    .busy     (busy_w),
    .arb      (arb_w),
    .last_bit (last_w),
    .mode     (mode_w),
    .shift    (shift_w),
    .ack_en   (ack_w),
    .div_sel  (div_w),
    .psc      (psc_w),
    .out_en   (out_en_w),
    .ctl_wr   (ctl_wr_w),
    .sta_wr   (sta_wr_w),
    .dat_wr   (dat_wr_w),
    .pend_clr (pend_clr_w),
    .irq      (irq)
  );

  twi_qtick #(.DIV_LO(DIV_LO), .DIV_HI(DIV_HI), .PSC_W(PSC_W)) u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (run_w),
    .div_sel(div_w),
    .psc    (psc_w),
    .tick   (tick_w)
  );

  twi_seq u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick_w),
    .run     (run_w),
    .ack_en  (ack_w),
    .sta_wr  (sta_wr_w),
    .dat_wr  (dat_wr_w),
    .pend_clr(pend_clr_w),
    .wdata   (reg_wdata),
    .sda_i   (sda_i),
    .busy    (busy_w),
    .mode    (mode_w),
    .pend    (pend_w),
    .arb     (arb_w),
    .last_bit(last_w),
    .shift   (shift_w),
    .scl_oe  (scl_oe),
    .sda_oe  (sda_oe)
  );
endmodule

// File: rtl/twi_byte_ctrl_chk.sv
module twi_byte_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_oe,
  input logic       sda_oe,
  input logic       pend,
  input logic       busy,
  input logic       arb,
  input logic       out_en,
  input logic [1:0] mode
);
  // R4: a paused transfer keeps SCL pulled low
  a_r4_scl_stretch: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && busy && $past(pend && busy)) |-> scl_oe);

  // R4: pending only rises out of an active transfer
  a_r4_pend_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend) |-> $past(busy));

  // R9: finishing a transfer with outputs enabled falls back to slave receive
  a_r9_slave_fallback: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && out_en) |-> (mode == 2'd0));

  // R10: arbitration loss raises pending and ends the transfer
  a_r10_arb_report: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(arb) |-> (pend && !busy));

  // R11: with outputs disabled for two samples both lines are released
  a_r11_float: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_en && !$past(out_en)) |-> (!scl_oe && !sda_oe));
endmodule

bind twi_byte_ctrl twi_byte_ctrl_chk u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .scl_oe(scl_oe),
  .sda_oe(sda_oe),
  .pend  (pend_w),
  .busy  (busy_w),
  .arb   (arb_w),
  .out_en(out_en_w),
  .mode  (mode_w)
);

// File: tb/sim_twi_byte_ctrl.sv
`timescale 1ns/1ps
module sim_twi_byte_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       scl_oe, sda_oe, irq;
  logic       scl_line, sda_line;
  logic       arb_force = 1'b0;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 1'b0;

  // slave model state
  int         sl_cnt = 0;
  int         sl_stops = 0;
  int         sl_txi = 0;
  logic       sl_first = 1'b0, sl_read = 1'b0, sl_ack = 1'b1, sl_drive = 1'b0, sl_mack = 1'b0;
  logic [7:0] sl_rx = 8'd0, sl_last_rx = 8'd0, sl_txb = 8'd0;
  logic [7:0] sl_txv [2];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign scl_line = !scl_oe;
  assign sda_line = !(sda_oe || sl_drive || arb_force);

  twi_byte_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .scl_i(scl_line),
    .sda_i(sda_line), .scl_oe(scl_oe), .sda_oe(sda_oe), .irq(irq)
  );

  always @(negedge sda_line) if (scl_line === 1'b1) begin
    sl_cnt = 0; sl_first = 1'b1; sl_read = 1'b0; sl_drive = 1'b0; sl_mack = 1'b0;
  end
  always @(posedge sda_line) if (scl_line === 1'b1) begin
    sl_stops = sl_stops + 1; sl_drive = 1'b0; sl_cnt = 0;
  end
  always @(posedge scl_line) begin
    if (sl_cnt < 8) sl_rx = {sl_rx[6:0], sda_line};
    else            sl_mack = sda_line;
    sl_cnt = sl_cnt + 1;
  end
  always @(negedge scl_line) begin
    if (sl_cnt == 8) begin
      sl_last_rx = sl_rx;
      if (sl_first) begin sl_read = sl_rx[0]; sl_drive = sl_ack; end
      else if (!sl_read) sl_drive = sl_ack;
      else sl_drive = 1'b0;
    end else if (sl_cnt == 9) begin
      sl_cnt = 0;
      if (sl_read && !sl_mack) begin
        sl_txb = sl_txv[sl_txi]; sl_txi = sl_txi + 1; sl_drive = !sl_txb[7];
      end else sl_drive = 1'b0;
      sl_first = 1'b0;
    end else if (sl_read && !sl_first && sl_cnt >= 1 && sl_cnt <= 7) begin
      sl_drive = !sl_txb[7-sl_cnt];
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk); reg_addr = a; #1 v = reg_rdata;
  endtask

  task automatic wait_pend();
    logic [7:0] v;
    for (int i = 0; i < 30000; i++) begin
      rd(2'd0, v);
      if (v[3]) break;
    end
  endtask

  task automatic wait_idle();
    logic [7:0] v;
    for (int i = 0; i < 30000; i++) begin
      rd(2'd1, v);
      if (!v[2]) break;
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic [7:0] v;
    int t0, t1, exp_per, stops0;
    sl_txv[0] = 8'hA5; sl_txv[1] = 8'h3C;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    sl_cnt = 0; sl_stops = 0; sl_drive = 1'b0;

    // R1 reset state
    rd(2'd0, v); chk(v == 8'h00, "R1 control", v, 0);
    rd(2'd1, v); chk(v == 8'h00, "R1 status", v, 0);
    chk(scl_line && sda_line, "R1 lines released", {scl_line, sda_line}, 3);
    chk(!irq, "R1 irq", irq, 0);

    // R12 own address readback
    wr(2'd2, 8'h5A);
    rd(2'd2, v); chk(v == 8'h5A, "R12 own address", v, 8'h5A);

    // R2/R3/R5/R6/R9 sweep of clock configurations
    for (int k = 0; k < 5; k++) begin
      logic [3:0] p;
      logic dv;
      dv = (k == 4);
      p = (k < 4) ? 4'(k) : 4'd0;
      exp_per = (dv ? 512 : 16) * (p + 1);
      sl_ack = 1'b1;
      wr(2'd0, {p, 1'b0, 1'b1, dv, 1'b1});
      wr(2'd1, 8'h0B);
      wr(2'd3, 8'h50);
      stops0 = sl_stops;
      wr(2'd1, 8'h0F);
      @(posedge scl_line); t0 = cyc;
      @(posedge scl_line); t1 = cyc;
      chk((t1 - t0) == exp_per, "R2 scl period", t1 - t0, exp_per);
      wait_pend();
      chk(sl_last_rx == 8'h50, "R3 address byte on bus", sl_last_rx, 8'h50);
      chk(irq == 1'b1, "R5 irq with enable", irq, 1);
      rd(2'd1, v);
      chk(v == 8'h0F, "R6 ack in status, busy, mode", v, 8'h0F);

      if (k == 0) begin
        repeat (50) @(negedge clk);
        chk(scl_line == 1'b0, "R4 scl held low", scl_line, 0);
        wr(2'd0, 8'h0D);
        rd(2'd0, v); chk(v[3] == 1'b1, "R4 write 1 keeps pending", v[3], 1);
        wr(2'd3, 8'h00);
        repeat (4) @(negedge clk);
        chk(sda_line == 1'b0, "R7 msb 0 on sda", sda_line, 0);
        wr(2'd3, 8'hC3);
        repeat (4) @(negedge clk);
        chk(sda_line == 1'b1, "R7 msb 1 on sda", sda_line, 1);
        wr(2'd0, 8'h05);
        wait_pend();
        chk(sl_last_rx == 8'hC3, "R7 data byte on bus", sl_last_rx, 8'hC3);
      end

      wr(2'd1, 8'h0B);
      wr(2'd0, {p, 1'b0, 1'b1, dv, 1'b1});
      wait_idle();
      rd(2'd1, v);
      chk(v == 8'h08, "R9 idle slave mode after stop", v, 8'h08);
      chk(sl_stops > stops0, "R9 stop on bus", sl_stops - stops0, 1);
      repeat (2) @(negedge clk);
      chk(scl_line && sda_line, "R9 lines released", {scl_line, sda_line}, 3);
    end

    // R6/R5 address not acknowledged, interrupt disabled
    sl_ack = 1'b0;
    wr(2'd0, 8'h01);
    wr(2'd1, 8'h0B); wr(2'd3, 8'h50); wr(2'd1, 8'h0F);
    wait_pend();
    rd(2'd1, v); chk(v[7] == 1'b1, "R6 nack in status", v[7], 1);
    chk(irq == 1'b0, "R5 irq masked", irq, 0);
    wr(2'd1, 8'h0B); wr(2'd0, 8'h01);
    wait_idle();

    // R8 master receive, ack then nack
    sl_ack = 1'b1; sl_txi = 0;
    wr(2'd0, 8'h05);
    wr(2'd1, 8'h0A); wr(2'd3, 8'h51); wr(2'd1, 8'h0E);
    wait_pend();
    wr(2'd0, 8'h05);
    wait_pend();
    rd(2'd3, v); chk(v == 8'hA5, "R8 first byte", v, 8'hA5);
    chk(sl_mack == 1'b0, "R8 master ack", sl_mack, 0);
    wr(2'd0, 8'h04);
    wait_pend();
    rd(2'd3, v); chk(v == 8'h3C, "R8 second byte", v, 8'h3C);
    chk(sl_mack == 1'b1, "R8 master nack", sl_mack, 1);
    wr(2'd1, 8'h0A); wr(2'd0, 8'h04);
    wait_idle();
    rd(2'd1, v); chk(v[1:0] == 2'd0, "R9 mode after read", v[1:0], 0);

    // R10 arbitration loss
    wr(2'd0, 8'h05);
    wr(2'd1, 8'h0B); wr(2'd3, 8'h50); wr(2'd1, 8'h0F);
    wait_pend();
    wr(2'd3, 8'hFF);
    @(negedge clk); arb_force = 1'b1;
    wr(2'd0, 8'h05);
    wait_pend();
    arb_force = 1'b0;
    repeat (3) @(negedge clk);
    rd(2'd1, v); chk(v == 8'h18, "R10 arbitration status", v, 8'h18);
    chk(scl_line && sda_line, "R10 lines released", {scl_line, sda_line}, 3);
    wr(2'd0, 8'h05);

    // R11 disabling outputs mid-transfer
    wr(2'd1, 8'h0B); wr(2'd3, 8'h50); wr(2'd1, 8'h0F);
    wait_pend();
    wr(2'd1, 8'h03);
    repeat (3) @(negedge clk);
    chk(scl_line && sda_line, "R11 lines released", {scl_line, sda_line}, 3);
    rd(2'd1, v); chk(v[2] == 1'b0, "R11 busy cleared", v[2], 0);
    wr(2'd0, 8'h05);

    done = 1'b1;
    finish_run();
  end
endmodule